// File: doc/BRIEF.md
# Multiplexed LCD Backplane and Segment Waveform Generator

This block drives a four-backplane multiplexed liquid crystal panel straight from ordinary tri-state pins. Each pin has an output-enable and a data output. A COM pin is driven to 0 or to full supply, or it is released. When released, an external pair of equal resistors holds it at mid-supply. SEG pins are always driven to 0 or to full supply. A frame is made of one phase per backplane. In each phase the active backplane is pulled low and then high. The segment pins carry the stored pattern and then its inverse, so the panel sees no DC component.

Every half-phase is an active interval followed by a dead interval, and the dead interval has a programmable length. During the dead interval all pins take a fixed pattern. One pattern pulls the RMS voltage down and the other pushes it up. Changing the dead length therefore sets the optical contrast with no extra parts. Two single-cycle pulse inputs step the dead length up or down, and it saturates at both ends. The active length sets the frame rate. The active length, the dead length, the trim direction and the segment image are all captured together at a frame boundary. As a result, no frame mixes old and new settings.

The sequencer is a four-state machine that runs in every phase:
- ACT_LO: the active interval of the first half.
- DEAD_LO: the dead interval of the first half.
- ACT_HI: the active interval of the second half.
- DEAD_HI: the dead interval of the second half.

The state machine has these transitions:
- ACT_LO→DEAD_LO, or ACT_LO→ACT_HI when the dead length is zero.
- DEAD_LO→ACT_HI.
- ACT_HI→DEAD_HI, or ACT_HI→ACT_LO of the next phase when the dead length is zero.
- DEAD_HI→ACT_LO of the next phase.

Leaving the last interval of the last phase is the frame wrap.

Top module: `lcdw_top`

## Requirements
- R1: While reset is held, the block is in ACT_LO of phase 0 with a blank image. COM0 is driven low, the other COM pins are released with data 0, and all SEG pins are driven low.
- R2: In an active interval, only the COM pin of the current phase has its enable set. Every other COM pin has enable 0 and data 0, so it is released.
- R3: In ACT_LO of phase p, COM p is driven low. SEG i is driven to bit i of backplane word p, which is bits [p*32+i] of the image input. All SEG enables are 1 at all times.
- R4: In ACT_HI of phase p, COM p is driven high and every SEG pin is driven to the inverse of its ACT_LO level.
- R5: With the trim input at 0 (lower RMS), both dead intervals drive every COM pin low and every SEG pin low.
- R6: With the trim input at 1 (raise RMS), DEAD_LO drives every COM pin low and every SEG pin high. DEAD_HI drives every COM pin high and every SEG pin low.
- R7: Phases run 0,1,2,3 and then repeat. Each phase runs ACT_LO, DEAD_LO, ACT_HI, DEAD_HI in that order. An active interval lasts max(active length,1) cycles and a dead interval lasts the dead length in cycles. A dead length of 0 removes both dead states.
- R8: An up pulse adds STEP to the pending dead length and a down pulse subtracts STEP. The result saturates at DEAD_MIN and DEAD_MAX, and up and down in the same cycle leave it unchanged. STEP is ceil((DEAD_MAX-DEAD_MIN)/DEAD_STEPS).
- R9: The pending dead length, the active length input, the trim input and the image input are captured only at the frame wrap. The captured values take effect from ACT_LO of phase 0 that follows. Before the first wrap, DEAD_INIT, ACT_INIT, trim 0 and a blank image apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_img_i | input | NCOM*NSEG | Segment image; word p (bits p*NSEG upward) belongs to backplane p |
| act_len_i | input | CNT_W | Active interval length in cycles (0 acts as 1) |
| trim_up_i | input | 1 | 1 selects the RMS-raising dead pattern, 0 the RMS-lowering one |
| dead_inc_i | input | 1 | Single-cycle request to lengthen the dead interval |
| dead_dec_i | input | 1 | Single-cycle request to shorten the dead interval |
| com_oe_o | output | NCOM | COM output enables (0 = released to mid-supply) |
| com_do_o | output | NCOM | COM output data |
| seg_oe_o | output | NSEG | SEG output enables |
| seg_do_o | output | NSEG | SEG output data |

## Verification
The embedded properties assume that DEAD_MIN is no greater than DEAD_INIT and DEAD_INIT is no greater than DEAD_MAX. They also assume that the dead-length requests are clean single-cycle pulses that the clock samples, with no bounce. The stimulus applies the requests only as one-cycle pulses, each separated by idle cycles. It also changes the image, active length and trim inputs mid-frame, so that capture happening only at the wrap is actually exercised. The stimulus pushes the dead length to both limits and beyond, including the zero length that removes the dead states. It also presses both requests in the same cycle and sets an active length of zero.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    // The four intervals of one backplane phase, in their running order
    typedef enum logic [1:0] {
        ST_ACT_LO  = 2'd0,
        ST_DEAD_LO = 2'd1,
        ST_ACT_HI  = 2'd2,
        ST_DEAD_HI = 2'd3
    } lcdw_state_e;

    function automatic logic is_active(input lcdw_state_e s);
        return (s == ST_ACT_LO) || (s == ST_ACT_HI);
    endfunction

endpackage

// File: rtl/lcdw_contrast.sv
module lcdw_contrast #(
    parameter int CNT_W      = 20,
    parameter int DEAD_MIN   = 0,
    parameter int DEAD_MAX   = 20000,
    parameter int DEAD_STEPS = 10,
    parameter int DEAD_INIT  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             wrap_i,
    output logic [CNT_W-1:0] dead_o
);

    localparam int STEP_RAW = (DEAD_MAX - DEAD_MIN + DEAD_STEPS - 1) / DEAD_STEPS;
    localparam int STEP     = (STEP_RAW < 1) ? 1 : STEP_RAW;

    logic [CNT_W-1:0] pend_q, pend_d, dead_q;
    logic [CNT_W:0]   up_sum;

    always_comb begin
        up_sum = {1'b0, pend_q} + (CNT_W+1)'(STEP);
        pend_d = pend_q;
        if (inc_i && !dec_i) begin
            if (up_sum > (CNT_W+1)'(DEAD_MAX))
                pend_d = CNT_W'(DEAD_MAX);
            else
                pend_d = up_sum[CNT_W-1:0];
        end else if (dec_i && !inc_i) begin
            if (pend_q < CNT_W'(DEAD_MIN + STEP))
                pend_d = CNT_W'(DEAD_MIN);
            else
                pend_d = pend_q - CNT_W'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= CNT_W'(DEAD_INIT);
            dead_q <= CNT_W'(DEAD_INIT);
        end else begin
            pend_q <= pend_d;
            if (wrap_i)
                dead_q <= pend_q;
        end
    end

    assign dead_o = dead_q;

    // R8: the pending length never leaves its programmed range
    p_pend_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q >= CNT_W'(DEAD_MIN)) && (pend_q <= CNT_W'(DEAD_MAX)));

    // R8: an opposed request pair leaves the pending value untouched
    p_opposed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(pend_q));

    // R9: the applied length moves only at a frame wrap
    p_dead_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(dead_q));

endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
    import lcdw_pkg::*;
#(
    parameter int NCOM     = 4,
    parameter int CNT_W    = 20,
    parameter int ACT_INIT = 1000,
    parameter int PH_W     = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] act_len_i,
    input  logic [CNT_W-1:0] dead_len_i,
    output lcdw_state_e      st_o,
    output logic [PH_W-1:0]  ph_o,
    output logic             wrap_o
);

    lcdw_state_e      st_q, st_d;
    logic [PH_W-1:0]  ph_q;
    logic [CNT_W-1:0] cnt_q, act_q, act_eff, len_cur;
    logic             last, ph_last, no_dead, next_ph, wrap;

    always_comb begin
        act_eff = (act_q == '0) ? CNT_W'(1) : act_q;
        len_cur = is_active(st_q) ? act_eff : dead_len_i;
        last    = (cnt_q == len_cur - CNT_W'(1));
        ph_last = (ph_q == PH_W'(NCOM - 1));
        no_dead = (dead_len_i == '0);
    end

    // next-state decision; moves only at the end of an interval
    always_comb begin
        st_d    = st_q;
        next_ph = 1'b0;
        if (last) begin
            unique case (st_q)
                ST_ACT_LO:  st_d = no_dead ? ST_ACT_HI : ST_DEAD_LO;
                ST_DEAD_LO: st_d = ST_ACT_HI;
                ST_ACT_HI: begin
                    st_d    = no_dead ? ST_ACT_LO : ST_DEAD_HI;
                    next_ph = no_dead;
                end
                ST_DEAD_HI: begin
                    st_d    = ST_ACT_LO;
                    next_ph = 1'b1;
                end
            endcase
        end
        wrap = next_ph && ph_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_ACT_LO;
            ph_q  <= '0;
            cnt_q <= '0;
            act_q <= CNT_W'(ACT_INIT);
        end else begin
            st_q  <= st_d;
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
            if (next_ph)
                ph_q <= ph_last ? '0 : ph_q + PH_W'(1);
            if (wrap)
                act_q <= act_len_i;
        end
    end

    assign st_o   = st_q;
    assign ph_o   = ph_q;
    assign wrap_o = wrap;

    // R7: the interval counter stays inside the current interval length
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len_cur);

    // R7: the phase cannot advance out of the first half
    p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACT_LO) |=> $stable(ph_q));

    // R7: the first-half active interval never jumps into the second-half dead state
    p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACT_LO) |=> (st_q != ST_DEAD_HI));

endmodule

// File: rtl/lcdw_pins.sv
module lcdw_pins
    import lcdw_pkg::*;
#(
    parameter int NCOM = 4,
    parameter int NSEG = 32,
    parameter int PH_W = (NCOM > 1) ? $clog2(NCOM) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  lcdw_state_e     st_i,
    input  logic [PH_W-1:0] ph_i,
    input  logic            trim_up_i,
    input  logic [NSEG-1:0] word_i,
    output logic [NCOM-1:0] com_oe_o,
    output logic [NCOM-1:0] com_do_o,
    output logic [NSEG-1:0] seg_oe_o,
    output logic [NSEG-1:0] seg_do_o
);

    logic act, dead;

    assign act  = is_active(st_i);
    assign dead = !act;

    for (genvar g = 0; g < NCOM; g++) begin : g_com
        logic mine;
        assign mine        = (ph_i == PH_W'(g));
        assign com_oe_o[g] = (act && mine) || dead;
        assign com_do_o[g] = ((st_i == ST_ACT_HI) && mine) ||
                             ((st_i == ST_DEAD_HI) && trim_up_i);
    end

    assign seg_oe_o = '1;

    always_comb begin
        unique case (st_i)
            ST_ACT_LO:  seg_do_o = word_i;
            ST_DEAD_LO: seg_do_o = {NSEG{trim_up_i}};
            ST_ACT_HI:  seg_do_o = ~word_i;
            ST_DEAD_HI: seg_do_o = '0;
        endcase
    end

    // R2: exactly one backplane enabled in an active interval
    p_one_com_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> ($countones(com_oe_o) == 1));

    // R2: a released COM pin carries no data
    p_released_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (com_do_o & ~com_oe_o) == '0);

endmodule

// File: rtl/lcdw_top.sv
module lcdw_top
    import lcdw_pkg::*;
#(
    parameter int NCOM       = 4,
    parameter int NSEG       = 32,
    parameter int CNT_W      = 20,
    parameter int ACT_INIT   = 1000,
    parameter int DEAD_MIN   = 0,
    parameter int DEAD_MAX   = 20000,
    parameter int DEAD_STEPS = 10,
    parameter int DEAD_INIT  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCOM*NSEG-1:0] seg_img_i,
    input  logic [CNT_W-1:0]     act_len_i,
    input  logic                 trim_up_i,
    input  logic                 dead_inc_i,
    input  logic                 dead_dec_i,
    output logic [NCOM-1:0]      com_oe_o,
    output logic [NCOM-1:0]      com_do_o,
    output logic [NSEG-1:0]      seg_oe_o,
    output logic [NSEG-1:0]      seg_do_o
);

    localparam int PH_W = (NCOM > 1) ? $clog2(NCOM) : 1;

    lcdw_state_e          st;
    logic [PH_W-1:0]      ph;
    logic                 wrap;
    logic [CNT_W-1:0]     dead_len;
    logic [NCOM*NSEG-1:0] img_q;
    logic                 trim_q;
    logic [NSEG-1:0]      word;

    lcdw_contrast #(
        .CNT_W(CNT_W), .DEAD_MIN(DEAD_MIN), .DEAD_MAX(DEAD_MAX),
        .DEAD_STEPS(DEAD_STEPS), .DEAD_INIT(DEAD_INIT)
    ) u_contrast (
        .clk(clk), .rst_n(rst_n), .inc_i(dead_inc_i), .dec_i(dead_dec_i),
        .wrap_i(wrap), .dead_o(dead_len)
    );

    lcdw_seq #(
        .NCOM(NCOM), .CNT_W(CNT_W), .ACT_INIT(ACT_INIT), .PH_W(PH_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .act_len_i(act_len_i), .dead_len_i(dead_len),
        .st_o(st), .ph_o(ph), .wrap_o(wrap)
    );

    // frame image and trim direction are captured together at the wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_q  <= '0;
            trim_q <= 1'b0;
        end else if (wrap) begin
            img_q  <= seg_img_i;
            trim_q <= trim_up_i;
        end
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < NCOM; k++)
            if (ph == PH_W'(k))
                word = img_q[k*NSEG +: NSEG];
    end

    lcdw_pins #(
        .NCOM(NCOM), .NSEG(NSEG), .PH_W(PH_W)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .st_i(st), .ph_i(ph), .trim_up_i(trim_q),
        .word_i(word), .com_oe_o(com_oe_o), .com_do_o(com_do_o),
        .seg_oe_o(seg_oe_o), .seg_do_o(seg_do_o)
    );

    // R9: the displayed image only changes at a frame wrap
    p_img_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(img_q));

    // R9: the trim direction only changes at a frame wrap
    p_trim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(trim_q));

endmodule

// File: tb/tb_lcdw_top.sv
module tb_lcdw_top;

    localparam int NCOM = 4, NSEG = 32, CW = 8;
    localparam int DMIN = 0, DMAX = 9, DSTEPS = 3, DINIT = 3, AINIT = 2;
    localparam int STEP = (DMAX - DMIN + DSTEPS - 1) / DSTEPS;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n = 1'b0;
    logic [NCOM*NSEG-1:0] img = '0;
    logic [CW-1:0]        act_len = CW'(2);
    logic                 trim = 1'b0, inc = 1'b0, dec = 1'b0;
    logic [NCOM-1:0]      com_oe, com_do;
    logic [NSEG-1:0]      seg_oe, seg_do;

    lcdw_top #(
        .NCOM(NCOM), .NSEG(NSEG), .CNT_W(CW), .ACT_INIT(AINIT),
        .DEAD_MIN(DMIN), .DEAD_MAX(DMAX), .DEAD_STEPS(DSTEPS), .DEAD_INIT(DINIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .seg_img_i(img), .act_len_i(act_len),
        .trim_up_i(trim), .dead_inc_i(inc), .dead_dec_i(dec),
        .com_oe_o(com_oe), .com_do_o(com_do), .seg_oe_o(seg_oe), .seg_do_o(seg_do)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // behavioural reference: interval kind 0..3 = ACT_LO, DEAD_LO, ACT_HI, DEAD_HI
    int m_st, m_ph, m_cnt, m_act, m_dead, m_pend;
    bit m_trim;
    logic [NCOM*NSEG-1:0] m_img;

    always @(posedge clk) begin
        int len, nxt, pn;
        bit endi, adv;
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_cnt = 0; m_act = AINIT;
            m_dead = DINIT; m_pend = DINIT; m_trim = 0; m_img = '0;
        end else begin
            len  = (m_st == 0 || m_st == 2) ? ((m_act == 0) ? 1 : m_act) : m_dead;
            endi = (m_cnt == len - 1);
            adv  = 0;
            nxt  = m_st;
            if (endi) begin
                if (m_dead == 0) begin
                    nxt = (m_st == 0) ? 2 : 0;
                    adv = (m_st == 2);
                end else begin
                    nxt = (m_st + 1) % 4;
                    adv = (m_st == 3);
                end
            end
            pn = m_pend;
            if (inc && !dec)      pn = (m_pend + STEP > DMAX) ? DMAX : m_pend + STEP;
            else if (dec && !inc) pn = (m_pend - STEP < DMIN) ? DMIN : m_pend - STEP;
            if (adv && m_ph == NCOM - 1) begin
                m_dead = m_pend; m_act = int'(act_len); m_trim = trim; m_img = img;
            end
            m_pend = pn;
            if (adv) m_ph = (m_ph + 1) % NCOM;
            m_st  = nxt;
            m_cnt = endi ? 0 : m_cnt + 1;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic [NCOM-1:0] e_oe, e_do;
        logic [NSEG-1:0] e_seg, w;
        string req;
        if (rst_n && !done) begin
            w = m_img[m_ph*NSEG +: NSEG];
            e_oe = '1; e_do = '0;
            case (m_st)
                0: begin e_oe = NCOM'(1) << m_ph; e_seg = w;  req = "R2 R3"; end
                1: begin e_seg = {NSEG{m_trim}}; req = m_trim ? "R6" : "R5"; end
                2: begin e_oe = NCOM'(1) << m_ph; e_do = NCOM'(1) << m_ph;
                         e_seg = ~w; req = "R2 R4"; end
                default: begin e_do = {NCOM{m_trim}}; e_seg = '0;
                         req = m_trim ? "R6" : "R5"; end
            endcase
            n_chk++;
            if (com_oe !== e_oe || com_do !== e_do || seg_do !== e_seg || seg_oe !== '1) begin
                n_bad++;
                $display("FAIL %s (sequence R7, dead length R8, capture R9) t=%0t: com_oe=%h/%h com_do=%h/%h seg_do=%h/%h seg_oe=%h (actual/expected)",
                         req, $time, com_oe, e_oe, com_do, e_do, seg_do, e_seg, seg_oe);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit up, input bit dn);
        @(negedge clk);
        inc = up; dec = dn;
        @(negedge clk);
        inc = 1'b0; dec = 1'b0;
        idle(3);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the pins
        n_chk++;
        if (com_oe !== 4'b0001 || com_do !== 4'b0000 || seg_do !== '0 || seg_oe !== '1) begin
            n_bad++;
            $display("FAIL R1 reset: com_oe=%h/1 com_do=%h/0 seg_do=%h/0 seg_oe=%h/ffffffff",
                     com_oe, com_do, seg_do, seg_oe);
        end
        rst_n = 1'b1;
        img = {32'hF0F0_1234, 32'h0000_FFFF, 32'hA5A5_5A5A, 32'h8000_0001};
        idle(60);
        img = {32'h1357_9BDF, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hDEAD_BEEF};   // mid-frame change
        idle(150);
        // R8: climb to and past the upper limit
        repeat (5) pulse(1'b1, 1'b0);
        idle(200);
        pulse(1'b1, 1'b1);                 // opposed pair, no effect
        img = {NCOM{32'h3C3C_C3C3}};
        idle(150);
        // R8 and R7: fall to zero and past it, dead states removed
        repeat (5) pulse(1'b0, 1'b1);
        idle(200);
        trim = 1'b1;                        // R6 pattern from next wrap
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        idle(250);
        act_len = '0;                       // R7: zero active length acts as one
        idle(200);
        act_len = CW'(5);
        trim = 1'b0;
        img = {32'h0000_0000, 32'hFFFF_FFFF, 32'h5555_AAAA, 32'h0102_0408};
        pulse(1'b0, 1'b1);
        idle(400);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog expired: finished=0 expected=1");
            summary();
            $finish;
        end
    end

endmodule